// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits beside a PCIe root port and watches the inbound memory writes that the port forwards as an address and a 32-bit data word. A write whose full 64-bit address equals a programmable target address is taken as a message-signalled interrupt. The low six bits of its data select one of up to 64 vectors. If that vector is enabled, its pending bit is latched.

Vectors are arranged in groups of 32. Each group has its own enable, mask and pending-status word, and its own level interrupt line. A group's line stays high while any pending bit in that group is not masked. Software reaches the target address and the group registers over a plain 32-bit register port. The port has an address, a write strobe, write data and combinational read data. Software acknowledges pending bits by writing ones back to the status word.

The group count is a parameter and may be 1 or 2. When only one group is built, the second group's registers, vectors and interrupt line are inert.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low.
- R2: The target address low word is read and written at offset 0x820, and the high word at offset 0x824. Together they form the 64-bit target address {high, low}.
- R3: For group g, the enable word is read and written at offset 0x828+12*g, and the mask word at offset 0x82C+12*g. Bit b of each word belongs to vector 32*g+b.
- R4: An inbound write with in_valid high, whose address equals the target address and whose vector in_data[5:0] is enabled, sets status bit in_data[5:0]%32 of group in_data[5:0]/32. The bit is readable at the next clock edge, and data bits 31..6 do not affect the decode.
- R5: An inbound write whose address differs from the target address in any bit, in either the low or the high word, leaves all status bits unchanged.
- R6: An inbound write to the target address for a vector whose enable bit is clear leaves all status bits unchanged.
- R7: The status word of group g is read at offset 0x830+12*g. Writing it clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: irq[g] is high exactly while some status bit of group g is set and its mask bit is clear. Setting a mask bit suppresses the line without clearing status.
- R9: When a vector event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R10: With one group built, reads of the group-1 registers (0x834, 0x838, 0x83C) return zero, writes to them are ignored, vectors 32 to 63 are dropped, and irq[1] stays low.
- R11: Reads of any offset other than the target address and group registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound memory write present this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data; bits 5..0 select the vector |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, same cycle |
| irq | output | 2 | Per-group level interrupt, bit g for group g |

## Verification
On every cycle, the assertions check four things. An accepted event always leaves its status bit set, even when a clearing write lands on it in the same cycle. Address misses and disabled vectors never change status. An interrupt line only rises after an inbound write or a register write, and only falls after a register write.

The exact register offsets and the read-back values are shown only by the bench scenarios. So are the decode of the vector into group and bit, and the exact level of each line against the mask. The inert second group of a one-group build is also shown only there; the bench runs that build side by side with the full one.

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl #(
  parameter int NUM_GROUPS = 2,
  parameter int RADDR_W = 12,
  parameter logic [RADDR_W-1:0] TGT_LO_OFF = 12'h820
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [63:0]        in_addr,
  input  logic [31:0]        in_data,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [1:0]         irq
);
  localparam int MAXG = 2;
  localparam int GW = 32;
  localparam int LGW = $clog2(GW);
  localparam int VEC_W = $clog2(MAXG * GW);
  localparam int STRIDE = 12;
  localparam logic [RADDR_W-1:0] TGT_HI_OFF = RADDR_W'(int'(TGT_LO_OFF) + 4);
  localparam int GRP_BASE = int'(TGT_LO_OFF) + 8;

  logic [31:0] tgt_lo_q, tgt_hi_q;
  logic [GW-1:0] en_q [MAXG];
  logic [GW-1:0] mask_q [MAXG];
  logic [GW-1:0] stat_q [MAXG];
  logic [31:0] rd_grp [MAXG];
  logic addr_hit;
  logic [VEC_W-1:0] vec;

  assign addr_hit = in_valid && (in_addr == {tgt_hi_q, tgt_lo_q});
  assign vec = in_data[VEC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == TGT_LO_OFF) tgt_lo_q <= reg_wdata;
      if (reg_addr == TGT_HI_OFF) tgt_hi_q <= reg_wdata;
    end
  end

  for (genvar g = 0; g < MAXG; g++) begin : g_grp
    localparam logic [RADDR_W-1:0] EN_OFF  = RADDR_W'(GRP_BASE + g * STRIDE);
    localparam logic [RADDR_W-1:0] MSK_OFF = RADDR_W'(GRP_BASE + g * STRIDE + 4);
    localparam logic [RADDR_W-1:0] ST_OFF  = RADDR_W'(GRP_BASE + g * STRIDE + 8);
    if (g < NUM_GROUPS) begin : g_on
      logic [GW-1:0] hit, clr;
      assign hit = (addr_hit && int'(vec[VEC_W-1:LGW]) == g)
                   ? (en_q[g] & (GW'(1) << vec[LGW-1:0])) : '0;
      assign clr = (reg_we && reg_addr == ST_OFF) ? reg_wdata : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[g]   <= '0;
          mask_q[g] <= '0;
          stat_q[g] <= '0;
        end else begin
          if (reg_we && reg_addr == EN_OFF)  en_q[g]   <= reg_wdata;
          if (reg_we && reg_addr == MSK_OFF) mask_q[g] <= reg_wdata;
          stat_q[g] <= (stat_q[g] & ~clr) | hit;
        end
      end

      assign irq[g] = |(stat_q[g] & ~mask_q[g]);
      assign rd_grp[g] = (reg_addr == EN_OFF)  ? en_q[g]   :
                         (reg_addr == MSK_OFF) ? mask_q[g] :
                         (reg_addr == ST_OFF)  ? stat_q[g] : '0;
    end else begin : g_off
      assign en_q[g]   = '0;
      assign mask_q[g] = '0;
      assign stat_q[g] = '0;
      assign irq[g]    = 1'b0;
      assign rd_grp[g] = '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == TGT_LO_OFF) reg_rdata = tgt_lo_q;
    if (reg_addr == TGT_HI_OFF) reg_rdata = tgt_hi_q;
    for (int g = 0; g < MAXG; g++) reg_rdata = reg_rdata | rd_grp[g];
  end
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_addr,
  input logic [31:0] in_data,
  input logic        reg_we,
  input logic [1:0]  irq,
  input logic [63:0] tgt,
  input logic [63:0] en,
  input logic [63:0] stat
);
  assert_vector_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr == tgt && en[in_data[5:0]]) |=> stat[$past(in_data[5:0])]);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr == tgt && en[in_data[5:0]] && reg_we) |=> stat[$past(in_data[5:0])]);

  assert_addr_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr != tgt && !reg_we) |=> $stable(stat));

  assert_disabled_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en[in_data[5:0]] && !reg_we) |=> $stable(stat));

  for (genvar g = 0; g < 2; g++) begin : g_irq
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> $past(in_valid || reg_we));
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[g]) |-> $past(reg_we));
  end
endmodule

bind msi_capture_ctrl msi_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
  .in_data(in_data), .reg_we(reg_we), .irq(irq),
  .tgt({tgt_hi_q, tgt_lo_q}),
  .en({en_q[1], en_q[0]}),
  .stat({stat_q[1], stat_q[0]})
);

// File: tb/tb_msi_capture_ctrl.sv
`timescale 1ns/100ps
module tb_msi_capture_ctrl;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic [11:0] reg_addr = '0;
  logic reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata2, rdata1;
  logic [1:0] irq2, irq1;

  always #2.5 clk = ~clk;

  msi_capture_ctrl #(.NUM_GROUPS(2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(rdata2), .irq(irq2));
  msi_capture_ctrl #(.NUM_GROUPS(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .irq(irq1));

  typedef struct {
    bit          single;
    bit          is_irq;
    int          grp;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_0000;

  always begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      if (it.is_irq) act = {31'b0, it.single ? irq1[it.grp] : irq2[it.grp]};
      else act = it.single ? rdata1 : rdata2;
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk_rd(bit single, logic [11:0] a, logic [31:0] e, string t);
    reg_addr = a; reg_we = 0;
    q.push_back('{single, 1'b0, 0, e, t});
    @(negedge clk);
  endtask

  task automatic chk_irq(bit single, int g, logic e, string t);
    q.push_back('{single, 1'b1, g, {31'b0, e}, t});
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic ev(logic [63:0] a, logic [31:0] d);
    in_addr = a; in_data = d; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_rd(0, 12'h820, 32'h0, "R1 tgt lo");
    chk_rd(0, 12'h824, 32'h0, "R1 tgt hi");
    chk_rd(0, 12'h828, 32'h0, "R1 enable0");
    chk_rd(0, 12'h82C, 32'h0, "R1 mask0");
    chk_rd(0, 12'h830, 32'h0, "R1 status0");
    chk_irq(0, 0, 1'b0, "R1 irq0");
    chk_irq(0, 1, 1'b0, "R1 irq1");
    // R2 target address
    wr(12'h820, TGT[31:0]);
    wr(12'h824, TGT[63:32]);
    chk_rd(0, 12'h820, 32'hFEE0_0000, "R2 tgt lo");
    chk_rd(0, 12'h824, 32'h0000_0001, "R2 tgt hi");
    // R3 init all ones
    wr(12'h828, '1); wr(12'h82C, '1); wr(12'h830, '1);
    wr(12'h834, '1); wr(12'h838, '1); wr(12'h83C, '1);
    chk_rd(0, 12'h828, 32'hFFFF_FFFF, "R3 enable0");
    chk_rd(0, 12'h838, 32'hFFFF_FFFF, "R3 mask1");
    chk_rd(0, 12'h83C, 32'h0, "R7 status1 after init clear");
    // R10 absent group in single build
    chk_rd(1, 12'h834, 32'h0, "R10 enable1 absent");
    chk_rd(1, 12'h838, 32'h0, "R10 mask1 absent");
    // R4 vector 5
    ev(TGT, 32'h0000_0005);
    chk_rd(0, 12'h830, 32'h0000_0020, "R4 vector5 status0");
    chk_irq(0, 0, 1'b0, "R8 masked irq0");
    wr(12'h82C, 32'hFFFF_FFDF);
    chk_irq(0, 0, 1'b1, "R8 unmasked irq0");
    chk_irq(0, 1, 1'b0, "R8 irq1 idle");
    // R4 vector 39 with upper data bits
    ev(TGT, 32'hABCD_0027);
    chk_rd(0, 12'h83C, 32'h0000_0080, "R4 vector39 status1");
    chk_rd(0, 12'h830, 32'h0000_0020, "R4 group0 untouched");
    chk_rd(1, 12'h830, 32'h0000_0020, "R10 single build group0");
    chk_rd(1, 12'h83C, 32'h0, "R10 vector39 dropped");
    // R5 address misses
    ev(64'h0000_0000_FEE0_0000, 32'h3);
    chk_rd(0, 12'h830, 32'h0000_0020, "R5 high word miss");
    ev(64'h0000_0001_FEE0_0004, 32'h3);
    chk_rd(0, 12'h830, 32'h0000_0020, "R5 low word miss");
    // R6 disabled vector
    wr(12'h828, 32'hFFFF_FFF7);
    ev(TGT, 32'h3);
    chk_rd(0, 12'h830, 32'h0000_0020, "R6 disabled vector3");
    ev(TGT, 32'h4);
    chk_rd(0, 12'h830, 32'h0000_0030, "R6 enabled vector4");
    // R7 write one to clear
    wr(12'h830, 32'h0000_0010);
    chk_rd(0, 12'h830, 32'h0000_0020, "R7 partial clear");
    chk_irq(0, 0, 1'b1, "R8 irq0 still pending");
    wr(12'h830, 32'h0000_0020);
    chk_rd(0, 12'h830, 32'h0, "R7 full clear");
    chk_irq(0, 0, 1'b0, "R8 irq0 after clear");
    // R9 collision
    in_addr = TGT; in_data = 32'h1; in_valid = 1;
    reg_addr = 12'h830; reg_wdata = 32'h2; reg_we = 1;
    @(negedge clk);
    in_valid = 0; reg_we = 0;
    chk_rd(0, 12'h830, 32'h0000_0002, "R9 event wins");
    chk_irq(0, 0, 1'b0, "R8 vector1 masked");
    wr(12'h830, 32'h0000_0002);
    chk_rd(0, 12'h830, 32'h0, "R7 write back value");
    // R8 group1 line
    chk_irq(0, 1, 1'b0, "R8 irq1 masked");
    wr(12'h838, 32'h0);
    chk_irq(0, 1, 1'b1, "R8 irq1 unmasked");
    chk_irq(1, 1, 1'b0, "R10 single irq1 low");
    chk_rd(1, 12'h838, 32'h0, "R10 mask1 write ignored");
    wr(12'h83C, 32'h0000_0080);
    chk_irq(0, 1, 1'b0, "R8 irq1 after clear");
    // R11 unmapped offsets
    chk_rd(0, 12'h900, 32'h0, "R11 unmapped 0x900");
    chk_rd(0, 12'h840, 32'h0, "R11 unmapped 0x840");
    @(negedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule